// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between instruction fetch and decode in a very-long-instruction-word pipeline. It takes in wide fetch packets, each carrying eight 32-bit instruction words. It splits the stream into execute packets, which are the groups of instructions meant to issue together. Bit 0 of every instruction word decides the grouping. A set bit links the word to the word that follows it. A cleared bit closes the group.

Each cycle the block issues at most one complete group. The group appears on a wide output bus, packed from slot 0 in program order, together with a contiguous valid mask. A group may start near the end of one fetch packet and finish in the next. When that happens, the block keeps the leading part internally and requests the next fetch packet. The joined group is issued once its closing word has arrived. The fetch side uses a valid/ready handshake, and the block asks for a new fetch packet only after every word of the held one has been used. A stall input from downstream freezes both issue and fetch requests without losing any word.

Top module: `vliw_dispatch`

## Requirements
- R1: While reset is low, `fetch_ready` and `disp_valid` are 0. After reset is released, `fetch_ready` is 0 until the first rising edge and rises after that edge, provided `stall` is low.
- R2: An issued group holds the instructions that follow the previous group, in program order, up to and including the first word whose bit 0 is 0. Instruction k of a fetch packet is at bits [32k+31:32k] of `fetch_data`, and output slot j is at bits [32j+31:32j] of `disp_data`.
- R3: When `stall` is low and the held fetch packet still contains a complete group, that group is issued in the cycle right after the previous one, so issue runs at one group per cycle.
- R4: `fetch_ready` is 0 while the held fetch packet has words that are not yet used. When a new fetch packet is accepted, every group that closes in earlier fetch packets has already been issued.
- R5: A group whose words span two fetch packets is issued once, as one group, after the fetch packet with its closing word is accepted. It is not padded and not split.
- R6: While `stall` is high, `fetch_ready` is 0, and in the following cycle `disp_valid` is 0. No instruction is lost or repeated as a result.
- R7: On an issued group of n words, `disp_mask` has bits [n-1:0] set and all other bits clear, and every unused slot of `disp_data` is zero.
- R8: A group of eight words is issued whole. This holds when it fills a fetch packet exactly and when it starts at any position from 1 to 7 of one fetch packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | A fetch packet is offered on `fetch_data` |
| fetch_ready | output | 1 | The block takes the offered fetch packet at this edge |
| fetch_data | input | SLOTS*IW | Eight instruction words, the first in program order at the low bits |
| stall | input | 1 | Downstream hold: no issue, no fetch request |
| disp_valid | output | 1 | One-cycle strobe: a group is on `disp_data` |
| disp_mask | output | SLOTS | Occupied slots of the issued group, contiguous from bit 0 |
| disp_data | output | SLOTS*IW | Issued group, packed from slot 0 |

## Verification
The assertions assume that the incoming stream is legal. No group is longer than eight words, so a ninth linked word never appears. Every group closes before the stream pauses. The stimulus satisfies this by building each stream only from group lengths between 1 and 8, with the last word of every group having bit 0 cleared. Each stream is also padded with one-word groups until it ends on a fetch-packet boundary. The streams sweep every fixed group length, place an eight-word group at every possible start position, and use pseudo-random length mixes with random stalls. The expected slots and masks for each stream are computed from its length list.

// File: rtl/dv_pkg.sv
// Package: shared constants for the execute packet dispatcher.
// Assumes one chain bit per instruction word, located at a fixed bit.
package dv_pkg;
    localparam int unsigned DV_SLOTS     = 8;   // instruction words per fetch packet
    localparam int unsigned DV_IW        = 32;  // bits per instruction word
    localparam int unsigned DV_CHAIN_BIT = 0;   // 1 = linked to the next word
endpackage

// File: rtl/dv_end_scan.sv
// dv_end_scan: locates the first word at or after the read pointer whose
// chain bit is clear, i.e. the word that closes the current group.
// Assumes ptr < SLOTS. Purely combinational.
module dv_end_scan #(
    parameter int unsigned SLOTS = dv_pkg::DV_SLOTS,
    parameter int unsigned IW    = dv_pkg::DV_IW,
    parameter int unsigned PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS*IW-1:0] words,
    input  logic [PW-1:0]       ptr,
    output logic                found,
    output logic [PW-1:0]       end_idx
);
    // Scan from the top down, so the lowest qualifying index wins.
    always_comb begin
        found   = 1'b0;
        end_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (i >= int'(ptr) && !words[i*IW + dv_pkg::DV_CHAIN_BIT]) begin
                found   = 1'b1;
                end_idx = PW'(i);
            end
        end
    end
endmodule

// File: rtl/dv_packer.sv
// dv_packer: joins the held partial group (carry) with the words of the
// current fetch packet from ptr up to end_idx (or to the last slot when no
// closing word is present). Produces slot-0-aligned data, the occupancy
// mask and the joined word count. Unused slots are driven to zero.
// Assumes carry_cnt < SLOTS and a legal stream (joined count <= SLOTS).
module dv_packer #(
    parameter int unsigned SLOTS = dv_pkg::DV_SLOTS,
    parameter int unsigned IW    = dv_pkg::DV_IW,
    parameter int unsigned PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int unsigned CW    = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS*IW-1:0] carry_data,
    input  logic [CW-1:0]       carry_cnt,
    input  logic [SLOTS*IW-1:0] fp_data,
    input  logic [PW-1:0]       ptr,
    input  logic [PW-1:0]       end_idx,
    input  logic                found,
    output logic [SLOTS*IW-1:0] join_data,
    output logic [SLOTS-1:0]    join_mask,
    output logic [CW:0]         join_cnt
);
    int lim;
    int src;

    // Place carried words first, then fresh words, in program order.
    always_comb begin
        lim       = found ? int'(end_idx) : int'(SLOTS) - 1;
        src       = 0;
        join_data = '0;
        join_mask = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (i < int'(carry_cnt)) begin
                join_data[i*IW +: IW] = carry_data[i*IW +: IW];
                join_mask[i]          = 1'b1;
            end else begin
                src = int'(ptr) + i - int'(carry_cnt);
                if (src >= 0 && src <= lim) begin
                    join_data[i*IW +: IW] = fp_data[src*IW +: IW];
                    join_mask[i]          = 1'b1;
                end
            end
        end
        join_cnt = (CW+1)'(int'(carry_cnt) + lim - int'(ptr) + 1);
    end
endmodule

// File: rtl/vliw_dispatch.sv
// vliw_dispatch: holds one fetch packet and a partial-group carry buffer,
// and issues one complete group per cycle on registered outputs.
// Assumes a legal stream: groups of 1..SLOTS words, each closed by a word
// whose chain bit is clear. Synchronous active-low reset.
module vliw_dispatch #(
    parameter int unsigned SLOTS = dv_pkg::DV_SLOTS,
    parameter int unsigned IW    = dv_pkg::DV_IW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_valid,
    output logic                fetch_ready,
    input  logic [SLOTS*IW-1:0] fetch_data,
    input  logic                stall,
    output logic                disp_valid,
    output logic [SLOTS-1:0]    disp_mask,
    output logic [SLOTS*IW-1:0] disp_data
);
    localparam int unsigned PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned CW = $clog2(SLOTS + 1);

    logic                run;
    logic                fp_valid;
    logic [SLOTS*IW-1:0] fp_q;
    logic [PW-1:0]       ptr;
    logic [SLOTS*IW-1:0] carry_q;
    logic [CW-1:0]       carry_cnt;

    logic                found;
    logic [PW-1:0]       end_idx;
    logic [SLOTS*IW-1:0] join_data;
    logic [SLOTS-1:0]    join_mask;
    logic [CW:0]         join_cnt;
    logic                accept;
    logic                work;

    dv_end_scan #(.SLOTS(SLOTS), .IW(IW), .PW(PW)) u_scan (
        .words   (fp_q),
        .ptr     (ptr),
        .found   (found),
        .end_idx (end_idx)
    );

    dv_packer #(.SLOTS(SLOTS), .IW(IW), .PW(PW), .CW(CW)) u_pack (
        .carry_data (carry_q),
        .carry_cnt  (carry_cnt),
        .fp_data    (fp_q),
        .ptr        (ptr),
        .end_idx    (end_idx),
        .found      (found),
        .join_data  (join_data),
        .join_mask  (join_mask),
        .join_cnt   (join_cnt)
    );

    // Request a fetch packet only when running, empty and not stalled.
    always_comb begin
        fetch_ready = run && !fp_valid && !stall;
        accept      = fetch_valid && fetch_ready;
        work        = fp_valid && !stall;
    end

    // Load fetch packets, issue groups, and carry partial groups forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            fp_valid   <= 1'b0;
            fp_q       <= '0;
            ptr        <= '0;
            carry_q    <= '0;
            carry_cnt  <= '0;
            disp_valid <= 1'b0;
            disp_mask  <= '0;
            disp_data  <= '0;
        end else begin
            run        <= 1'b1;
            disp_valid <= 1'b0;
            disp_mask  <= '0;
            if (accept) begin
                fp_q     <= fetch_data;
                fp_valid <= 1'b1;
                ptr      <= '0;
            end else if (work) begin
                if (found) begin
                    disp_valid <= 1'b1;
                    disp_mask  <= join_mask;
                    disp_data  <= join_data;
                    carry_cnt  <= '0;
                    if (end_idx == PW'(SLOTS - 1)) begin
                        fp_valid <= 1'b0;
                    end else begin
                        ptr <= end_idx + 1'b1;
                    end
                end else begin
                    carry_q   <= join_data;
                    carry_cnt <= join_cnt[CW-1:0];
                    fp_valid  <= 1'b0;
                end
            end
        end
    end

    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_mask[0] && ((disp_mask & (disp_mask + 1'b1)) == '0))); // R7
    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !disp_valid); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(ptr) && $stable(carry_cnt) && $stable(fp_valid))); // R6
    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready) |=> (fp_valid && ptr == '0 && !disp_valid)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && !stall && found) |-> (join_cnt <= (CW+1)'(SLOTS))); // R2
    AST_CARRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        carry_cnt < CW'(SLOTS)); // R5
endmodule

// File: tb/vliw_dispatch_test.sv
module vliw_dispatch_test;
    localparam int SLOTS = 8;
    localparam int IW    = 32;
    localparam int LIMIT = 2000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                fetch_valid = 1'b0;
    logic                fetch_ready;
    logic [SLOTS*IW-1:0] fetch_data = '0;
    logic                stall = 1'b0;
    logic                disp_valid;
    logic [SLOTS-1:0]    disp_mask;
    logic [SLOTS*IW-1:0] disp_data;

    always #2 clk = ~clk;  // 250 MHz

    vliw_dispatch #(.SLOTS(SLOTS), .IW(IW)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_data(fetch_data), .stall(stall), .disp_valid(disp_valid),
        .disp_mask(disp_mask), .disp_data(disp_data)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [0:511];
    int plen  [0:255];
    int pstart[0:255];
    int n_instr;
    int n_pkt;
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd(input int m);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % m);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_stream();
        n_instr = 0;
        n_pkt   = 0;
    endtask

    // Word = (running index + 1) << 1, with bit 0 set on every word but the last.
    task automatic add_pkt(input int len);
        pstart[n_pkt] = n_instr;
        plen[n_pkt]   = len;
        for (int j = 0; j < len; j++) begin
            mem[n_instr + j] = (32'(n_instr + j + 1) << 1) | {31'd0, (j != len - 1)};
        end
        n_instr += len;
        n_pkt++;
    endtask

    task automatic pad_stream();
        while (n_instr % SLOTS != 0) add_pkt(1);
    endtask

    task automatic run_stream(input int stall_mode);
        int fi = 0;
        int pi = 0;
        int cyc = 0;
        bit prev_open = 1'b0;
        bit prev_stall = 1'b0;
        bit acc;
        int n_fp;
        int pend;
        string tag;
        logic [SLOTS-1:0] emask;
        logic [31:0] eword;
        n_fp = n_instr / SLOTS;
        rst_n = 1'b0; fetch_valid = 1'b0; stall = 1'b0;
        repeat (3) @(negedge clk);
        check(!fetch_ready && !disp_valid, "R1", "quiet in reset",
              {62'd0, fetch_ready, disp_valid}, 64'd0);
        rst_n = 1'b1;
        #1;
        check(!fetch_ready, "R1", "ready before first edge", 64'(fetch_ready), 64'd0);
        @(negedge clk);
        check(fetch_ready, "R1", "ready after release", 64'(fetch_ready), 64'd1);
        while (pi < n_pkt && cyc < LIMIT) begin
            // Monitor the registered outputs.
            if (prev_stall) check(!disp_valid, "R6", "issue after stall", 64'(disp_valid), 64'd0);
            if (disp_valid) begin
                if (pi >= n_pkt) begin
                    check(1'b0, "R2", "extra group", 64'(disp_mask), 64'd0);
                end else begin
                    pend = pstart[pi] + plen[pi] - 1;
                    tag = (plen[pi] == SLOTS) ? "R8" :
                          ((pstart[pi] / SLOTS != pend / SLOTS) ? "R5" : "R2");
                    emask = SLOTS'((1 << plen[pi]) - 1);
                    check(disp_mask == emask, "R7", "mask", 64'(disp_mask), 64'(emask));
                    for (int j = 0; j < SLOTS; j++) begin
                        eword = (j < plen[pi]) ? mem[pstart[pi] + j] : 32'd0;
                        check(disp_data[j*IW +: IW] == eword,
                              (j < plen[pi]) ? tag : "R7", $sformatf("slot %0d", j),
                              64'(disp_data[j*IW +: IW]), 64'(eword));
                    end
                    prev_open = (pend % SLOTS) != SLOTS - 1;
                    pi++;
                end
            end else begin
                if (prev_open && !prev_stall && pi < n_pkt &&
                    (pstart[pi] + plen[pi] - 1) < SLOTS * fi)
                    check(1'b0, "R3", "missed back-to-back issue", 64'd0, 64'd1);
                if (!prev_stall) prev_open = 1'b0;
            end
            // Drive the next cycle.
            stall = (stall_mode == 0) ? 1'b0 : (rnd(4) < stall_mode);
            fetch_valid = (fi < n_fp);
            for (int j = 0; j < SLOTS; j++)
                fetch_data[j*IW +: IW] = (fi < n_fp) ? mem[fi*SLOTS + j] : 32'd0;
            #1;
            if (stall) check(!fetch_ready, "R6", "ready under stall", 64'(fetch_ready), 64'd0);
            acc = fetch_valid && fetch_ready;
            if (acc && pi < n_pkt)
                check((pstart[pi] + plen[pi] - 1) >= SLOTS * fi, "R4", "fetch before drain",
                      64'(pstart[pi] + plen[pi] - 1), 64'(SLOTS * fi));
            prev_stall = stall;
            @(posedge clk);
            if (acc) fi++;
            @(negedge clk);
            cyc++;
        end
        fetch_valid = 1'b0; stall = 1'b0;
        if (cyc >= LIMIT) check(1'b0, "R3", "watchdog expired", 64'(pi), 64'(n_pkt));
        @(negedge clk);
        check(!disp_valid && fetch_ready, "R4", "idle after stream",
              {62'd0, disp_valid, fetch_ready}, 64'd1);
    endtask

    initial begin
        // Fixed lengths 1..8, with and without stalls.
        for (int len = 1; len <= SLOTS; len++) begin
            for (int sm = 0; sm < 2; sm++) begin
                clear_stream();
                for (int k = 0; k < SLOTS; k++) add_pkt(len);
                run_stream(sm);
            end
        end
        // Eight-word group at every start offset.
        for (int s = 1; s < SLOTS; s++) begin
            for (int sm = 0; sm < 3; sm += 2) begin
                clear_stream();
                add_pkt(s); add_pkt(SLOTS); add_pkt(SLOTS - s);
                run_stream(sm);
            end
        end
        // Pseudo-random length mixes with random stalls.
        for (int r = 0; r < 10; r++) begin
            clear_stream();
            for (int k = 0; k < 40; k++) add_pkt(rnd(SLOTS) + 1);
            pad_stream();
            run_stream(1 + (r % 2));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule